// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital front end of a single-channel 12-bit digital-to-analog converter. A host sends 16-bit command words over a serial port made of a bit clock, a data line, a frame strobe and an active-low chip select. The block oversamples all four pins with its own system clock and assembles each framed word. It then applies the word to a 12-bit conversion latch or to a 2-bit reference-source register. The analog core reads the block's outputs: the conversion code, a fast/slow settling selector, a power-down request and the reference choice. A one-cycle strobe tells the analog core when a new code is valid.

Every word carries a speed bit and a power bit next to a two-bit target select. The select bits sit at word bits 15 and 12. A frame opens on a falling frame strobe and normally ends after sixteen bits. The host may end a frame early by raising the frame strobe. The held chip select can also be tied low, so the port works with three wires.

The frame controller has three states. IDLE waits for a frame to open. SHIFT collects bits. ARMED holds a complete sixteen-bit word until the next rising bit clock. The transitions are:
- IDLE to SHIFT when the frame strobe falls while selected.
- SHIFT to SHIFT on each captured bit, and on a fresh frame-strobe fall, which restarts the frame.
- SHIFT to ARMED when the sixteenth bit is captured.
- SHIFT to IDLE when the frame strobe rises, which commits the bits taken so far or discards an empty frame.
- ARMED to IDLE on a rising bit clock or a rising frame strobe, which commits the word.
- Any state to IDLE when chip select goes inactive, which drops the frame.

Top module: `dac_cmd_rx`

## Requirements
- R1: After reset the conversion code, speed, power-down and reference outputs are all zero and no strobe is issued.
- R2: While `cs_n` is high the block ignores the pins: a full word sent with `cs_n` high changes no output, and raising `cs_n` in the middle of a frame discards the bits already received.
- R3: A frame opens on a falling `fs`. Data on `din` is captured on each falling `sclk`, first bit into word bit 15.
- R4: A word whose select bits {bit 15, bit 12} are 00 loads bits 11..0 into `dac_code` and raises `update_pulse` for exactly one system clock.
- R5: A word with select 11 loads payload bits 1..0 into `ref_sel`, ignores payload bits 11..2 and gives no strobe. The reference codes are 00 external, 01 internal low (1.024 V), 10 internal high (2.048 V) and 11 external.
- R6: A word with select 01 or 10 changes no output and gives no strobe.
- R7: On a select-00 or select-11 word, bit 14 drives `fast_mode` (1 fast, 0 slow) and bit 13 drives `power_down` (1 powered down).
- R8: For a full word, outputs and the strobe change only after the first rising `sclk` that follows the sixteenth captured bit, and not before it.
- R9: If `fs` rises after 1 to 15 captured bits, the partial word is committed left-aligned at bit 15, with the missing low bits read as zero.
- R10: If `fs` rises before any bit is captured, the frame is discarded and no output changes.
- R11: `ref_sel` keeps its value across select-00 data writes.
- R12: With `cs_n` held low throughout, back-to-back framed words are each applied in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the `sclk` rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial bit clock (asynchronous) |
| din | input | 1 | Serial data, captured on falling `sclk` |
| fs | input | 1 | Frame strobe: a fall opens a frame, a rise closes it |
| cs_n | input | 1 | Active-low select |
| dac_code | output | 12 | Conversion latch contents |
| fast_mode | output | 1 | 1 selects fast settling, 0 slow |
| power_down | output | 1 | 1 requests power-down |
| ref_sel | output | 2 | Reference source code |
| update_pulse | output | 1 | One-cycle strobe on each conversion-latch write |

## Verification
Four rules are checked on every cycle:
- The strobe never lasts longer than one cycle.
- The conversion code changes only in a cycle that carries the strobe.
- A reference change never carries the strobe.
- No output moves in the cycle after the synchronized select is seen inactive.

The checks also confirm that the outputs are zero on leaving reset.

Only the directed scenarios can show the rest:
- the bit order and field positions of a word;
- the effect of each select code;
- the left alignment of partial frames and the discarding of empty or aborted ones;
- the exact point where a full word takes effect relative to the rising bit clock.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    // Fixed serial word geometry: the field positions are decoded by the register bank.
    localparam int WORD_W   = 16;
    localparam int DATA_W   = 12;
    localparam int REF_W    = 2;
    localparam int SEL_HI_B = 15;
    localparam int SPD_B    = 14;
    localparam int PWR_B    = 13;
    localparam int SEL_LO_B = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_ARMED = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        SEL_DATA  = 2'b00,
        SEL_RSV_A = 2'b01,
        SEL_RSV_B = 2'b10,
        SEL_CTRL  = 2'b11
    } target_sel_e;

    // Pin positions inside the synchronizer vector.
    localparam int PIN_DIN  = 0;
    localparam int PIN_SCLK = 1;
    localparam int PIN_FS   = 2;
    localparam int PIN_CS_N = 3;
    localparam int PIN_N    = 4;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] prev_o
);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic [STAGES-1:0] chain;
            logic              hist;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{RST_VAL[gi]}};
                    hist  <= RST_VAL[gi];
                end else begin
                    chain <= {chain[STAGES-2:0], pin_i[gi]};
                    hist  <= chain[STAGES-1];
                end
            end

            assign lvl_o[gi]  = chain[STAGES-1];
            assign prev_o[gi] = hist;
        end
    endgenerate

endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
    import dac_cmd_pkg::*;
#(
    parameter int BITS  = WORD_W,
    localparam int CNT_W = $clog2(BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_act,
    input  logic             fs_fall,
    input  logic             fs_rise,
    input  logic             sclk_fall,
    input  logic             sclk_rise,
    output logic             shift_en,
    output logic             clr_en,
    output logic             commit_en,
    output logic [CNT_W-1:0] bit_cnt
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BITS - 1);

    rx_state_e state_q, state_d;

    // State register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (clr_en)
                bit_cnt <= '0;
            else if (shift_en)
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_act && fs_fall)
                    state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!cs_act)
                    state_d = ST_IDLE;
                else if (fs_fall)
                    state_d = ST_SHIFT;
                else if (fs_rise)
                    state_d = ST_IDLE;
                else if (sclk_fall && bit_cnt == LAST_IDX)
                    state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!cs_act)
                    state_d = ST_IDLE;
                else if (fs_fall)
                    state_d = ST_SHIFT;
                else if (sclk_rise || fs_rise)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        shift_en  = 1'b0;
        clr_en    = 1'b0;
        commit_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                clr_en = cs_act && fs_fall;
            end
            ST_SHIFT: begin
                if (cs_act) begin
                    if (fs_fall)
                        clr_en = 1'b1;
                    else if (fs_rise)
                        commit_en = (bit_cnt != '0);
                    else if (sclk_fall)
                        shift_en = 1'b1;
                end
            end
            ST_ARMED: begin
                if (cs_act) begin
                    if (fs_fall)
                        clr_en = 1'b1;
                    else if (sclk_rise || fs_rise)
                        commit_en = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/shift_capture.sv
module shift_capture #(
    parameter int  BITS  = 16,
    localparam int CNT_W = $clog2(BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic             shift_en,
    input  logic             bit_i,
    input  logic [CNT_W-1:0] bit_cnt,
    output logic [BITS-1:0]  word_o
);

    logic [BITS-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh_q <= '0;
        else if (clr_en)
            sh_q <= '0;
        else if (shift_en)
            sh_q <= {sh_q[BITS-2:0], bit_i};
    end

    // Left-align whatever has arrived: the first bit always lands on the top position.
    always_comb begin
        word_o = sh_q << (BITS - int'(bit_cnt));
    end

endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import dac_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_en,
    input  logic [WORD_W-1:0] word_i,
    output logic [DATA_W-1:0] dac_code,
    output logic              fast_mode,
    output logic              power_down,
    output logic [REF_W-1:0]  ref_sel,
    output logic              update_pulse
);

    target_sel_e sel;

    always_comb begin
        sel = target_sel_e'({word_i[SEL_HI_B], word_i[SEL_LO_B]});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_code     <= '0;
            fast_mode    <= 1'b0;
            power_down   <= 1'b0;
            ref_sel      <= '0;
            update_pulse <= 1'b0;
        end else begin
            update_pulse <= 1'b0;
            if (commit_en) begin
                unique case (sel)
                    SEL_DATA: begin
                        dac_code     <= word_i[DATA_W-1:0];
                        fast_mode    <= word_i[SPD_B];
                        power_down   <= word_i[PWR_B];
                        update_pulse <= 1'b1;
                    end
                    SEL_CTRL: begin
                        ref_sel      <= word_i[REF_W-1:0];
                        fast_mode    <= word_i[SPD_B];
                        power_down   <= word_i[PWR_B];
                    end
                    SEL_RSV_A, SEL_RSV_B: ;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx
    import dac_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              fs,
    input  logic              cs_n,
    output logic [DATA_W-1:0] dac_code,
    output logic              fast_mode,
    output logic              power_down,
    output logic [REF_W-1:0]  ref_sel,
    output logic              update_pulse
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    // Idle levels: deselected, strobe high, clock high, data low.
    localparam logic [PIN_N-1:0] PIN_IDLE = 4'b1110;

    logic [PIN_N-1:0] pin_raw, pin_lvl, pin_prev;
    logic             cs_act, fs_fall, fs_rise, sclk_fall, sclk_rise;
    logic             shift_en, clr_en, commit_en;
    logic [CNT_W-1:0] bit_cnt;
    logic [WORD_W-1:0] word;

    always_comb begin
        pin_raw           = '0;
        pin_raw[PIN_DIN]  = din;
        pin_raw[PIN_SCLK] = sclk;
        pin_raw[PIN_FS]   = fs;
        pin_raw[PIN_CS_N] = cs_n;
    end

    pin_sync #(
        .WIDTH   (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_raw),
        .lvl_o  (pin_lvl),
        .prev_o (pin_prev)
    );

    always_comb begin
        cs_act    = ~pin_lvl[PIN_CS_N];
        fs_fall   = pin_prev[PIN_FS]   & ~pin_lvl[PIN_FS];
        fs_rise   = ~pin_prev[PIN_FS]  &  pin_lvl[PIN_FS];
        sclk_fall = pin_prev[PIN_SCLK] & ~pin_lvl[PIN_SCLK];
        sclk_rise = ~pin_prev[PIN_SCLK] & pin_lvl[PIN_SCLK];
    end

    frame_fsm #(
        .BITS (WORD_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .fs_fall   (fs_fall),
        .fs_rise   (fs_rise),
        .sclk_fall (sclk_fall),
        .sclk_rise (sclk_rise),
        .shift_en  (shift_en),
        .clr_en    (clr_en),
        .commit_en (commit_en),
        .bit_cnt   (bit_cnt)
    );

    shift_capture #(
        .BITS (WORD_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (clr_en),
        .shift_en (shift_en),
        .bit_i    (pin_lvl[PIN_DIN]),
        .bit_cnt  (bit_cnt),
        .word_o   (word)
    );

    reg_bank u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_en    (commit_en),
        .word_i       (word),
        .dac_code     (dac_code),
        .fast_mode    (fast_mode),
        .power_down   (power_down),
        .ref_sel      (ref_sel),
        .update_pulse (update_pulse)
    );

endmodule

// File: rtl/dac_cmd_rx_chk.sv
module dac_cmd_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_act,
    input logic [11:0] dac_code,
    input logic        fast_mode,
    input logic        power_down,
    input logic [1:0]  ref_sel,
    input logic        update_pulse
);

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_code == '0 && !fast_mode && !power_down && ref_sel == '0 && !update_pulse));

    p_deselect_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> ($stable(dac_code) && $stable(fast_mode) && $stable(power_down) && $stable(ref_sel) && !update_pulse));

    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        update_pulse |=> !update_pulse);

    p_code_with_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> update_pulse);

    p_ref_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_sel) |-> !update_pulse);

endmodule

bind dac_cmd_rx dac_cmd_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_act       (cs_act),
    .dac_code     (dac_code),
    .fast_mode    (fast_mode),
    .power_down   (power_down),
    .ref_sel      (ref_sel),
    .update_pulse (update_pulse)
);

// File: tb/dac_cmd_rx_test.sv
module dac_cmd_rx_test;

    localparam int HALF = 10;       // system cycles per half serial clock
    localparam int WD   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        din = 1'b0;
    logic        fs = 1'b1;
    logic        cs_n = 1'b1;
    logic [11:0] dac_code;
    logic        fast_mode, power_down, update_pulse;
    logic [1:0]  ref_sel;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dac_cmd_rx uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk         (sclk),
        .din          (din),
        .fs           (fs),
        .cs_n         (cs_n),
        .dac_code     (dac_code),
        .fast_mode    (fast_mode),
        .power_down   (power_down),
        .ref_sel      (ref_sel),
        .update_pulse (update_pulse)
    );

    always @(posedge clk) if (rst_n && update_pulse) strobes <= strobes + 1;

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input int code, input int fst, input int pd,
                             input int rs, input int nstb);
        check(req, "dac_code", int'(dac_code), code);
        check(req, "fast_mode", int'(fast_mode), fst);
        check(req, "power_down", int'(power_down), pd);
        check(req, "ref_sel", int'(ref_sel), rs);
        check(req, "strobes", strobes, nstb);
    endtask

    task automatic send_bits(input logic [15:0] w, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            din = w[15-i];
            cyc(HALF);
            sclk = 1'b0;
            cyc(HALF);
            sclk = 1'b1;
        end
    endtask

    task automatic xfer(input logic [15:0] w, input int nbits, input logic csv);
        cs_n = csv;
        cyc(5);
        fs = 1'b0;
        cyc(5);
        send_bits(w, nbits);
        cyc(5);
        fs = 1'b1;
        cyc(10);
    endtask

    task automatic t_reset();
        check_all("R1", 0, 0, 0, 0, 0);
    endtask

    task automatic t_data_write();
        xfer(16'h4A5C, 16, 1'b0);        // R3 R4 R7: select 00, fast, running
        check_all("R4", 'hA5C, 1, 0, 0, 1);
    endtask

    task automatic t_ctrl_write();
        xfer(16'hBFFE, 16, 1'b0);        // R5 R7: select 11, slow, power-down, ref 10
        check_all("R5", 'hA5C, 0, 1, 2, 1);
        xfer(16'hD001, 16, 1'b0);        // select 11, fast, running, ref 01
        check_all("R7", 'hA5C, 1, 0, 1, 1);
    endtask

    task automatic t_reserved();
        xfer(16'h7123, 16, 1'b0);        // select 01
        check_all("R6", 'hA5C, 1, 0, 1, 1);
        xfer(16'hE456, 16, 1'b0);        // select 10
        check_all("R6", 'hA5C, 1, 0, 1, 1);
    endtask

    task automatic t_retain();
        xfer(16'h0321, 16, 1'b0);
        check_all("R11", 'h321, 0, 0, 1, 2);
    endtask

    task automatic t_commit_point();
        cs_n = 1'b0;
        cyc(5);
        fs = 1'b0;
        cyc(5);
        for (int i = 0; i < 16; i++) begin
            din = 16'h4FFF >> (15 - i);
            cyc(HALF);
            sclk = 1'b0;
            cyc(HALF);
            if (i != 15) sclk = 1'b1;
        end
        cyc(HALF);                       // clock still low after the sixteenth bit
        check_all("R8", 'h321, 0, 0, 1, 2);
        sclk = 1'b1;
        cyc(8);
        check_all("R8", 'hFFF, 1, 0, 1, 3);
        cyc(5);
        fs = 1'b1;
        cyc(10);
        check("R8", "strobes_after_fs", strobes, 3);
    endtask

    task automatic t_partial();
        xfer(16'h0A00, 8, 1'b0);
        check_all("R9", 'hA00, 0, 0, 1, 4);
        xfer(16'h4BC0, 12, 1'b0);
        check_all("R9", 'hBC0, 1, 0, 1, 5);
        xfer(16'hB000, 3, 1'b0);         // low select bit missing -> select 10, reserved
        check_all("R9", 'hBC0, 1, 0, 1, 5);
    endtask

    task automatic t_empty();
        xfer(16'h0000, 0, 1'b0);
        check_all("R10", 'hBC0, 1, 0, 1, 5);
    endtask

    task automatic t_deselect();
        xfer(16'h0123, 16, 1'b1);
        check_all("R2", 'hBC0, 1, 0, 1, 5);
        cs_n = 1'b0;
        cyc(5);
        fs = 1'b0;
        cyc(5);
        send_bits(16'h0000, 8);
        cs_n = 1'b1;
        cyc(10);
        fs = 1'b1;
        cyc(10);
        check_all("R2", 'hBC0, 1, 0, 1, 5);
    endtask

    task automatic t_three_wire();
        cs_n = 1'b0;
        xfer(16'h0111, 16, 1'b0);
        check("R12", "first_code", int'(dac_code), 'h111);
        xfer(16'h4222, 16, 1'b0);
        check_all("R12", 'h222, 1, 0, 1, 7);
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(10);
        t_reset();
        t_data_write();
        t_ctrl_write();
        t_reserved();
        t_retain();
        t_commit_point();
        t_partial();
        t_empty();
        t_deselect();
        t_three_wire();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule